// File: doc/BRIEF.md
# Bus Request Generator With Hold

This block produces the bus-request line that a processor core presents to an external bus arbiter, and it tracks whether the core currently owns the external bus. Several access sources inside the core each flag a pending access and whether that access targets the external bus. Only external targets raise the request. Accesses to internal memories never reach the request line.

A software-controlled hold bit can pin the request high even when nothing is pending. The same bit also selects what happens in low-power stop or wait. With hold clear, the request falls. With hold set, the request is frozen at its last value. Ownership follows the arbiter's grant and is independent of the request. The block therefore stays master with its request low while the arbiter keeps granting it (bus parking). Ownership is given up only once any transfer still in flight has finished. A hardware reset clears the request and returns the block to the slave state.

Top module: `busreq_gen`

## Requirements
- R1: Outside low power with hold clear, `bus_req` equals, one clock later, the OR over all ports of `acc_vld[i] & acc_ext[i]`.
- R2: A port with `acc_vld` high and `acc_ext` low (internal access) has no effect on `bus_req`.
- R3: Outside low power with `req_hold` high, `bus_req` is high one clock later whatever the pending accesses are.
- R4: With `bus_grant` high, `is_master` stays high while `bus_req` is low (parking).
- R5: While `rst_n` is low, `bus_req` and `is_master` are both low.
- R6: With `low_pwr` high and `req_hold` low at a clock edge, `bus_req` is low after that edge.
- R7: With `low_pwr` high and `req_hold` high at a clock edge, `bus_req` keeps its value across that edge.
- R8: `bus_grant` sampled high at a clock edge makes `is_master` high after that edge.
- R9: `bus_grant` and `xfer_busy` both sampled low at a clock edge make `is_master` low after that edge.
- R10: `bus_grant` sampled low while `xfer_busy` is high leaves `is_master` unchanged across that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| acc_vld | input | N_PORT | Per-port access pending |
| acc_ext | input | N_PORT | Per-port access targets the external bus |
| req_hold | input | 1 | Software hold bit |
| low_pwr | input | 1 | Core is in stop or wait |
| bus_grant | input | 1 | Grant from the external arbiter |
| xfer_busy | input | 1 | An external bus cycle is in progress |
| bus_req | output | 1 | Bus request to the arbiter, active high |
| is_master | output | 1 | High while the block owns the external bus |

## Verification
The bench sweeps every combination of the two-port access flags, hold, low power, grant and busy. It runs the sweep twice in different orders, so that each combination is met from many prior request and ownership states. The sweep is what catches an internal access that wrongly raises the request, and a stop/wait case that keeps the request when hold is clear or drops it when hold is set. Directed sequences cover the remaining failure modes. A design without parking would drop mastership as soon as the request falls. A design that ignored `xfer_busy` would release the bus in the middle of a cycle. A design with a faulty reset would leave the request or ownership set after `rst_n` is asserted in the middle of activity.

// File: rtl/busreq_pkg.sv
package busreq_pkg;
    typedef struct packed {
        logic req;
        logic mst;
    } brq_state_t;

    localparam brq_state_t BRQ_RESET = '{req: 1'b0, mst: 1'b0};
endpackage

// File: rtl/brq_need.sv
module brq_need #(
    parameter int N_PORT = 2
) (
    input  logic [N_PORT-1:0] acc_vld,
    input  logic [N_PORT-1:0] acc_ext,
    output logic              need
);
    logic [N_PORT-1:0] hit;

    for (genvar g = 0; g < N_PORT; g++) begin : g_port
        assign hit[g] = acc_vld[g] & acc_ext[g];
    end

    assign need = |hit;
endmodule

// File: rtl/brq_req_ctl.sv
module brq_req_ctl (
    input  logic need,
    input  logic req_hold,
    input  logic low_pwr,
    input  logic req_q,
    output logic req_d
);
    always_comb begin
        if (low_pwr) begin
            req_d = req_hold ? req_q : 1'b0;
        end else begin
            req_d = need | req_hold;
        end
    end
endmodule

// File: rtl/brq_own_ctl.sv
module brq_own_ctl (
    input  logic bus_grant,
    input  logic xfer_busy,
    input  logic mst_q,
    output logic mst_d
);
    always_comb begin
        if (bus_grant) begin
            mst_d = 1'b1;
        end else if (xfer_busy) begin
            mst_d = mst_q;
        end else begin
            mst_d = 1'b0;
        end
    end
endmodule

// File: rtl/busreq_gen.sv
module busreq_gen
    import busreq_pkg::*;
#(
    parameter int N_PORT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PORT-1:0] acc_vld,
    input  logic [N_PORT-1:0] acc_ext,
    input  logic              req_hold,
    input  logic              low_pwr,
    input  logic              bus_grant,
    input  logic              xfer_busy,
    output logic              bus_req,
    output logic              is_master
);
    brq_state_t st_d, st_q;
    logic       need;
    logic       req_nx;
    logic       mst_nx;

    brq_need #(.N_PORT(N_PORT)) i_need (
        .acc_vld (acc_vld),
        .acc_ext (acc_ext),
        .need    (need)
    );

    brq_req_ctl i_req (
        .need     (need),
        .req_hold (req_hold),
        .low_pwr  (low_pwr),
        .req_q    (st_q.req),
        .req_d    (req_nx)
    );

    brq_own_ctl i_own (
        .bus_grant (bus_grant),
        .xfer_busy (xfer_busy),
        .mst_q     (st_q.mst),
        .mst_d     (mst_nx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = req_nx;
        st_d.mst = mst_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= BRQ_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_req   = st_q.req;
    assign is_master = st_q.mst;
endmodule

// File: rtl/busreq_gen_chk.sv
module busreq_gen_chk #(
    parameter int N_PORT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_PORT-1:0] acc_vld,
    input logic [N_PORT-1:0] acc_ext,
    input logic              req_hold,
    input logic              low_pwr,
    input logic              bus_grant,
    input logic              xfer_busy,
    input logic              bus_req,
    input logic              is_master
);
    a_r5_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (!bus_req && !is_master));

    a_r1_req_tracks_need: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(low_pwr) && !$past(req_hold))
        |-> (bus_req == (|($past(acc_vld) & $past(acc_ext)))));

    a_r3_hold_forces: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(low_pwr) && $past(req_hold)) |-> bus_req);

    a_r6_lowpwr_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(low_pwr) && !$past(req_hold)) |-> !bus_req);

    a_r7_lowpwr_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(low_pwr) && $past(req_hold)) |-> $stable(bus_req));

    a_r8_grant_master: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_grant)) |-> is_master);

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_grant) && !$past(xfer_busy)) |-> !is_master);

    a_r10_busy_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_grant) && $past(xfer_busy)) |-> $stable(is_master));
endmodule

bind busreq_gen busreq_gen_chk #(.N_PORT(N_PORT)) i_busreq_gen_chk (.*);

// File: tb/test_busreq_gen.sv
module test_busreq_gen;
    localparam int  N_PORT   = 2;
    localparam time CLK_PER  = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_PORT-1:0] acc_vld = '0;
    logic [N_PORT-1:0] acc_ext = '0;
    logic              req_hold = 1'b0;
    logic              low_pwr = 1'b0;
    logic              bus_grant = 1'b0;
    logic              xfer_busy = 1'b0;
    logic              bus_req;
    logic              is_master;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    logic exp_req = 1'b0;
    logic exp_mst = 1'b0;

    busreq_gen #(.N_PORT(N_PORT)) i_busreq_gen (.*);

    always #(CLK_PER/2) clk = ~clk;

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] v);
        acc_vld   = v[1:0];
        acc_ext   = v[3:2];
        req_hold  = v[4];
        low_pwr   = v[5];
        bus_grant = v[6];
        xfer_busy = v[7];
    endtask

    // step one clock with model update, then compare at the falling edge
    task automatic step_chk();
        logic need;
        string rt, mt;
        need = |(acc_vld & acc_ext);
        if (low_pwr) begin
            exp_req = req_hold ? exp_req : 1'b0;
            rt = req_hold ? "R7" : "R6";
        end else begin
            exp_req = need | req_hold;
            rt = req_hold ? "R3" : ((|(acc_vld & ~acc_ext)) ? "R2" : "R1");
        end
        if (bus_grant) begin
            exp_mst = 1'b1;
            mt = exp_req ? "R8" : "R4";
        end else if (xfer_busy) begin
            mt = "R10";
        end else begin
            exp_mst = 1'b0;
            mt = "R9";
        end
        @(negedge clk);
        check(rt, bus_req, exp_req);
        check(mt, is_master, exp_mst);
    endtask

    initial begin
        #(CLK_PER * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R5", bus_req, 1'b0);
        check("R5", is_master, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep: two passes in different orders
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 256; i++) begin
                int k;
                k = (p == 0) ? i : ((i * 37 + 11) % 256);
                apply(8'(k));
                step_chk();
            end
        end

        // R2: internal-only accesses never raise the request
        apply(8'h00);
        step_chk();
        acc_vld = 2'b11; acc_ext = 2'b00;
        for (int n = 0; n < 4; n++) begin
            step_chk();
            check("R2", bus_req, 1'b0);
        end

        // R4: parking, grant held, request falls, master kept
        apply(8'h00);
        acc_vld = 2'b01; acc_ext = 2'b01; bus_grant = 1'b1;
        step_chk();
        acc_vld = 2'b00;
        for (int n = 0; n < 3; n++) begin
            step_chk();
            check("R4", bus_req, 1'b0);
            check("R4", is_master, 1'b1);
        end

        // R10 then R9: grant drops during a busy cycle
        bus_grant = 1'b0; xfer_busy = 1'b1;
        step_chk();
        check("R10", is_master, 1'b1);
        xfer_busy = 1'b0;
        step_chk();
        check("R9", is_master, 1'b0);

        // R7 frozen high, then R6 drop
        apply(8'h00);
        acc_vld = 2'b10; acc_ext = 2'b10;
        step_chk();
        req_hold = 1'b1; low_pwr = 1'b1; acc_vld = 2'b00;
        for (int n = 0; n < 3; n++) begin
            step_chk();
            check("R7", bus_req, 1'b1);
        end
        req_hold = 1'b0;
        step_chk();
        check("R6", bus_req, 1'b0);

        // R5: reset in the middle of activity
        apply(8'h00);
        req_hold = 1'b1; bus_grant = 1'b1;
        step_chk();
        #1 rst_n = 1'b0;
        #1;
        check("R5", bus_req, 1'b0);
        check("R5", is_master, 1'b0);
        apply(8'h00);
        exp_req = 1'b0; exp_mst = 1'b0;
        @(negedge clk);
        check("R5", bus_req, 1'b0);
        check("R5", is_master, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule